// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load-Use Stall Unit

This block is the hazard logic of a five-stage in-order integer pipeline. While an instruction is being decoded, it compares that instruction's two source register numbers with the destinations of the three older instructions still in flight, in the execute, memory and write-back stages. For each operand it returns a 2-bit select code that tells the operand multiplexers where the value comes from: the register file or one of the three downstream stages.

Some dependences cannot be covered by forwarding. A load that is still in execute has no data yet, so a consumer directly behind it must wait one cycle. The unit detects this case from the select codes it has just produced. It raises a stall, which holds the PC and the decode instruction register, and a bubble, which clears the control fields entering execute. The block is purely combinational and holds no state.

Top module: `fwd_stall_unit`

## Requirements
- R1: Select code 0 means "take the register file value". It is produced for an operand when no stage qualifies as a producer of that operand's register.
- R2: Select code 1 means "forward from the execute stage". It is produced when the execute stage has its write flag set and its destination equals the source register.
- R3: Select code 2 means "forward from the memory stage". It is produced when the memory stage qualifies and the execute stage does not.
- R4: Select code 3 means "forward from the write-back stage". It is produced when only the write-back stage qualifies.
- R5: When several stages qualify, the youngest one wins, in the order execute, then memory, then write-back.
- R6: A stage whose write flag is clear never qualifies, whatever its destination. A bubble in a stage arrives with its write flag clear, so it is never a producer.
- R7: A source register number of 0 always gives select code 0, even when a stage writes register 0.
- R8: The first operand is resolved from `src_a` (the Rs field) and the second from `src_b` (the Rt field). Each is resolved independently under the same rules, so the two codes can differ.
- R9: `stall` is 1 exactly when `ex_load` is 1 and at least one select code equals 1.
- R10: `bubble` is 1 exactly when `stall` is 1.
- R11: The select codes keep the values given by R1 to R8 while `stall` is high. A stall does not force them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | REG_W | First source register number (Rs) of the decoding instruction |
| src_b | input | REG_W | Second source register number (Rt) of the decoding instruction |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction reads memory (it is a load) |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register of the write-back-stage instruction |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| sel_a | output | 2 | Source select for the first operand (0 register file, 1 execute, 2 memory, 3 write-back) |
| sel_b | output | 2 | Source select for the second operand, same encoding as `sel_a` |
| stall | output | 1 | Hold the PC and the decode instruction register |
| bubble | output | 1 | Zero the control fields entering execute |

## Verification
The hardest case to reach is one where several stages claim the same source register and the winner is not the obvious one. Examples are a write-flag-clear execute stage sitting in front of a valid memory producer, or a load in execute that matches only one operand while the other operand resolves to write-back. Uniformly random register numbers almost never collide, so the random stimulus draws every register number from the range 0 to 3. This makes three-way matches, register-0 sources and load-use pairs frequent. Directed sequences add the classic cases: a load followed directly by its consumer, a load whose consumer sits two slots behind it, operands fed from two different stages, and a producer that writes register 0.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    // operand source select encoding; the datapath muxes decode these values
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_WB  = 2'd3
    } opsel_e;

    // number of downstream producer stages examined
    localparam int unsigned NUM_STAGES = 3;

    // number of source operands per instruction
    localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/fsu_operand_sel.sv
module fsu_operand_sel
    import fsu_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output opsel_e           sel
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic [NUM_STAGES-1:0] hit;
        opsel_e                sel;
    } sel_state_t;

    sel_state_t sel_d;

    always_comb begin
        sel_d = '{hit: '0, sel: SRC_RF};
        // a stage qualifies only when it writes and targets this source
        sel_d.hit[0] = ex_wr  && (ex_dst  == src);
        sel_d.hit[1] = mem_wr && (mem_dst == src);
        sel_d.hit[2] = wb_wr  && (wb_dst  == src);
        if (src == ZERO_REG) begin
            sel_d.sel = SRC_RF;
        end else if (sel_d.hit[0]) begin
            sel_d.sel = SRC_EX;
        end else if (sel_d.hit[1]) begin
            sel_d.sel = SRC_MEM;
        end else if (sel_d.hit[2]) begin
            sel_d.sel = SRC_WB;
        end else begin
            sel_d.sel = SRC_RF;
        end
    end

    assign sel = sel_d.sel;

endmodule

// File: rtl/fsu_stall_gen.sv
module fsu_stall_gen
    import fsu_pkg::*;
(
    input  logic                      ex_load,
    input  logic [NUM_OPS-1:0][1:0]   sels,
    output logic                      stall,
    output logic                      bubble
);

    typedef struct packed {
        logic [NUM_OPS-1:0] from_ex;
        logic               stall;
    } stall_state_t;

    stall_state_t st_d;

    always_comb begin
        st_d = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            st_d.from_ex[i] = (sels[i] == SRC_EX);
        end
        // load data is not ready while the load is still in execute
        st_d.stall = ex_load && (|st_d.from_ex);
    end

    assign stall  = st_d.stall;
    assign bubble = st_d.stall;

endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import fsu_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             stall,
    output logic             bubble
);

    logic [NUM_OPS-1:0][REG_W-1:0] src_vec;
    logic [NUM_OPS-1:0][1:0]       sel_vec;

    assign src_vec[0] = src_a;
    assign src_vec[1] = src_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        opsel_e op_sel;
        fsu_operand_sel #(.REG_W(REG_W)) u_sel (
            .src     (src_vec[g]),
            .ex_dst  (ex_dst),
            .ex_wr   (ex_wr),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (op_sel)
        );
        assign sel_vec[g] = op_sel;
    end

    fsu_stall_gen u_stall (
        .ex_load (ex_load),
        .sels    (sel_vec),
        .stall   (stall),
        .bubble  (bubble)
    );

    assign sel_a = sel_vec[0];
    assign sel_b = sel_vec[1];

endmodule

// File: rtl/chk_fwd_stall_unit.sv
module chk_fwd_stall_unit #(
    parameter int unsigned REG_W = 5
) (
    input logic [REG_W-1:0] src_a,
    input logic [REG_W-1:0] src_b,
    input logic [REG_W-1:0] ex_dst,
    input logic             ex_wr,
    input logic             ex_load,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wr,
    input logic [REG_W-1:0] wb_dst,
    input logic             wb_wr,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b,
    input logic             stall,
    input logic             bubble
);

    always_comb begin
        if (src_a == '0) begin
            assert_src0_a_R7: assert (sel_a == 2'd0)
                else $error("sel_a nonzero for register 0");
        end
        if (src_b == '0) begin
            assert_src0_b_R7: assert (sel_b == 2'd0)
                else $error("sel_b nonzero for register 0");
        end
        if (sel_a == 2'd1) begin
            assert_ex_a_R2: assert (ex_wr && ex_dst == src_a)
                else $error("sel_a=1 without execute producer");
        end
        if (sel_b == 2'd2) begin
            assert_mem_prio_b_R5: assert (mem_wr && mem_dst == src_b && !(ex_wr && ex_dst == src_b))
                else $error("sel_b=2 while execute also qualifies or memory does not");
        end
        if (sel_a == 2'd3) begin
            assert_wb_a_R4: assert (wb_wr && wb_dst == src_a
                                    && !(ex_wr && ex_dst == src_a)
                                    && !(mem_wr && mem_dst == src_a))
                else $error("sel_a=3 with younger producer or no write-back producer");
        end
        if (stall) begin
            assert_stall_R9: assert (ex_load && (sel_a == 2'd1 || sel_b == 2'd1))
                else $error("stall without a load-use dependence");
        end
        if (ex_load && src_a != '0 && ex_wr && ex_dst == src_a) begin
            assert_loaduse_R9: assert (stall)
                else $error("load-use on operand a not stalled");
        end
        if (bubble) begin
            assert_bubble_R10: assert (ex_load && stall)
                else $error("bubble without load stall");
        end
    end

endmodule

bind fwd_stall_unit chk_fwd_stall_unit #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_fwd_stall_unit.sv
`timescale 1ns/1ps
module sim_fwd_stall_unit;

    localparam int unsigned REG_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [REG_W-1:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
    logic ex_wr, ex_load, mem_wr, wb_wr;
    logic [1:0] sel_a, sel_b;
    logic stall, bubble;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    fwd_stall_unit #(.REG_W(REG_W)) u0 (.*);

    function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] s);
        if (s == 0) return 2'd0;
        if (ex_wr && ex_dst == s) return 2'd1;
        if (mem_wr && mem_dst == s) return 2'd2;
        if (wb_wr && wb_dst == s) return 2'd3;
        return 2'd0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int a, input int b,
                         input int exd, input bit exw, input bit ld,
                         input int md, input bit mw, input int wd, input bit ww);
        @(negedge clk);
        src_a = REG_W'(a); src_b = REG_W'(b);
        ex_dst = REG_W'(exd); ex_wr = exw; ex_load = ld;
        mem_dst = REG_W'(md); mem_wr = mw; wb_dst = REG_W'(wd); wb_wr = ww;
        #1;
    endtask

    task automatic check_all(input string tag);
        logic [1:0] ea, eb;
        logic es;
        ea = exp_sel(src_a);
        eb = exp_sel(src_b);
        es = ex_load && (ea == 2'd1 || eb == 2'd1);
        chk({tag, " R8 sel_a"}, sel_a, ea);
        chk({tag, " R8 sel_b"}, sel_b, eb);
        chk({tag, " R9 stall"}, stall, es);
        chk({tag, " R10 bubble"}, bubble, es);
    endtask

    initial begin
        src_a = '0; src_b = '0; ex_dst = '0; mem_dst = '0; wb_dst = '0;
        ex_wr = 0; ex_load = 0; mem_wr = 0; wb_wr = 0;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R1 idle state: nothing writes
        chk("R1 reset sel_a", sel_a, 0);
        chk("R1 reset sel_b", sel_b, 0);
        chk("R9 reset stall", stall, 0);

        // R2 execute producer, ALU (no load)
        drive(4, 7, 4, 1, 0, 0, 0, 0, 0);
        chk("R2 ex fwd", sel_a, 1);
        chk("R9 no stall non-load", stall, 0);
        // R3 memory producer
        drive(7, 9, 1, 1, 0, 7, 1, 0, 0);
        chk("R3 mem fwd", sel_a, 2);
        // R4 write-back producer
        drive(3, 9, 1, 1, 0, 2, 1, 9, 1);
        chk("R4 wb fwd", sel_b, 3);
        // R5 all three match: execute wins; then memory over write-back
        drive(6, 6, 6, 1, 0, 6, 1, 6, 1);
        chk("R5 prio ex", sel_a, 1);
        drive(6, 6, 6, 0, 0, 6, 1, 6, 1);
        chk("R5 prio mem", sel_b, 2);
        // R6 write flag clear (bubble) in execute -> memory used
        drive(5, 0, 5, 0, 1, 5, 1, 0, 0);
        chk("R6 wr clear no match", sel_a, 2);
        chk("R6 no stall from bubble", stall, 0);
        drive(5, 0, 5, 0, 0, 5, 0, 5, 0);
        chk("R6 all clear", sel_a, 0);
        // R7 register 0 destination
        drive(0, 0, 0, 1, 1, 0, 1, 0, 1);
        chk("R7 reg0 a", sel_a, 0);
        chk("R7 reg0 b", sel_b, 0);
        chk("R7 reg0 no stall", stall, 0);
        // R9 load directly followed by consumer (operand b)
        drive(2, 8, 8, 1, 1, 0, 0, 0, 0);
        chk("R9 load-use stall", stall, 1);
        chk("R10 load-use bubble", bubble, 1);
        chk("R11 sel held in stall", sel_b, 1);
        // R9 load two slots ahead: now in memory, no stall, code 2
        drive(8, 2, 3, 1, 0, 8, 1, 0, 0);
        chk("R3 load two ahead", sel_a, 2);
        chk("R9 load two ahead no stall", stall, 0);
        // R8 operands from different stages
        drive(10, 11, 12, 1, 1, 10, 1, 11, 1);
        chk("R8 a from mem", sel_a, 2);
        chk("R8 b from wb", sel_b, 3);
        chk("R9 load no match no stall", stall, 0);
        // R11 stall with the other operand from write-back
        drive(13, 14, 14, 1, 1, 0, 0, 13, 1);
        chk("R11 a wb during stall", sel_a, 3);
        chk("R9 stall b", stall, 1);

        // constrained random: register numbers 0..3 to force collisions
        for (int i = 0; i < 3000; i++) begin
            drive(int'($urandom_range(3)), int'($urandom_range(3)),
                  int'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                  int'($urandom_range(3)), 1'($urandom_range(1)),
                  int'($urandom_range(3)), 1'($urandom_range(1)));
            check_all("rand");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule